// File: doc/BRIEF.md
# Counting Bloom Filter Search Gate

This block sits beside a load/store queue and decides, for every memory operation that executes, whether that operation must run the costly associative search of the queue. It keeps two direct-mapped tables of small saturating counters. One table records the hashed addresses of in-flight loads and the other records those of in-flight stores. An issuing load probes the store table, and an issuing store probes the load table. A zero counter proves that no in-flight operation of the opposite kind shares the bucket, so the search can be skipped. A nonzero counter means a true match or a hash alias, so the search is required. In the same cycle the issuing operation adds itself to its own kind's table.

When an operation commits, the retire port removes it from its table. A counter that would pass its maximum value freezes instead. A frozen bucket answers every probe with a search and ignores later inserts and removes. The block counts frozen buckets across both tables. Once that count reaches a set limit, it raises a flush request and holds it until the pipeline flushes. A clear pulse, given on a flush or a branch mispredict when nothing remains in flight, empties both tables at once.

Top module: `bloom_search_gate`

## Requirements
- R1: After reset every counter is zero and no bucket is frozen, so any issue gets `search_req` low, and `flush_req` is low.
- R2: `search_req` is combinational in the issue cycle. It is high only when `iss_valid` is high and the probed bucket holds a nonzero count or is frozen. A load (`iss_store`=0) probes the store table and a store (`iss_store`=1) probes the load table.
- R3: An issue adds one to the counter at its hashed index in its own kind's table at the next clock edge. A retire (`ret_store` selects the table) subtracts one at its hashed index.
- R4: When an issue and a retire of the same kind reach the same bucket in the same cycle, that counter is left unchanged.
- R5: A counter holds values up to 2^CNT_W-1. An insert at that value freezes the bucket. A frozen bucket forces a search on every probe, and inserts and removes leave it unchanged until a clear.
- R6: The number of frozen buckets in both tables is tracked. `flush_req` rises at the clock edge on which that number reaches FREEZE_LIMIT, and it stays high until a clear.
- R7: `clr` zeroes all counters, frozen flags and `flush_req` at the next edge. An issue or retire in the same cycle has no effect.
- R8: The bucket index is the hash of the address. With HASH_MODE=1 (the default), index bit i is addr[i] XOR addr[i+IDX_W]. With HASH_MODE=0 the index is addr[IDX_W-1:0]. IDX_W is log2(DEPTH).
- R9: A retire that reaches a zero, unfrozen counter leaves it at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Flash clear of all state |
| iss_valid | input | 1 | A memory operation executes this cycle |
| iss_store | input | 1 | Kind of the issuing operation: 1 store, 0 load |
| iss_addr | input | ADDR_W | Address of the issuing operation |
| ret_valid | input | 1 | A memory operation commits this cycle |
| ret_store | input | 1 | Kind of the committing operation: 1 store, 0 load |
| ret_addr | input | ADDR_W | Address of the committing operation |
| search_req | output | 1 | The issuing operation must search the queue |
| flush_req | output | 1 | Too many frozen buckets; pipeline flush requested |

## Verification
The hardest state to reach from the ports is a table with several frozen buckets, split between both kinds, with the flush threshold crossed exactly on one edge. Random traffic seldom piles eight unretired operations onto a single bucket. Directed sequences therefore hammer chosen buckets, including address pairs that alias under the XOR hash, and check `flush_req` one freeze before the limit and on the freeze that reaches it. Constrained random traffic over a small address pool, with aliased members and occasional clears, then mixes inserts, removes, same-bucket collisions and freezes against a bench model.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  localparam int unsigned CNT_W_MAX = 6;

  typedef logic [CNT_W_MAX-1:0] wide_cnt_t;

  typedef struct packed {
    wide_cnt_t nxt;
    logic      freeze;
  } cnt_step_t;

  // One bucket update: increment saturates into a freeze, decrement
  // stops at zero, frozen buckets never move.
  function automatic cnt_step_t cnt_step(input wide_cnt_t cur,
                                         input wide_cnt_t top,
                                         input logic      inc,
                                         input logic      frozen);
    cnt_step_t r;
    r.nxt    = cur;
    r.freeze = 1'b0;
    if (!frozen) begin
      if (inc) begin
        if (cur == top) r.freeze = 1'b1;
        else            r.nxt    = cur + 1'b1;
      end else if (cur != '0) begin
        r.nxt = cur - 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/bsg_hash.sv
module bsg_hash #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned HASH_MODE = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned USED_W = (HASH_MODE == 0) ? IDX_W : 2 * IDX_W;

  generate
    if (HASH_MODE == 0) begin : g_direct
      assign idx = addr[IDX_W-1:0];
    end else begin : g_xor
      for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        assign idx[i] = addr[i] ^ addr[i + IDX_W];
      end
    end
    if (ADDR_W > USED_W) begin : g_rest
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:USED_W];
    end
  endgenerate

endmodule

// File: rtl/bsg_count_table.sv
module bsg_count_table
  import bsg_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CNT_W = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             rem_en,
  input  logic [IDX_W-1:0] rem_idx,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             probe_hit,
  output logic             freeze_evt
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic             frz_q [DEPTH];

  // Named internal events for the checks below
  logic             collide, ins_go, rem_go;
  logic [CNT_W-1:0] ins_cur, rem_cur;
  logic             ins_frz, rem_frz;
  cnt_step_t        ins_res, rem_res;

  assign collide = ins_en && rem_en && (ins_idx == rem_idx);
  assign ins_go  = ins_en && !collide;
  assign rem_go  = rem_en && !collide;

  assign ins_cur = cnt_q[ins_idx];
  assign rem_cur = cnt_q[rem_idx];
  assign ins_frz = frz_q[ins_idx];
  assign rem_frz = frz_q[rem_idx];

  assign ins_res = cnt_step(wide_cnt_t'(ins_cur), wide_cnt_t'(CNT_TOP), 1'b1, ins_frz);
  assign rem_res = cnt_step(wide_cnt_t'(rem_cur), wide_cnt_t'(CNT_TOP), 1'b0, rem_frz);

  assign freeze_evt = ins_go && ins_res.freeze && !clr;
  assign probe_hit  = frz_q[probe_idx] || (cnt_q[probe_idx] != '0);

  generate
    for (genvar b = 0; b < DEPTH; b++) begin : g_bucket
      logic hit_ins, hit_rem;
      assign hit_ins = ins_go && (ins_idx == IDX_W'(b));
      assign hit_rem = rem_go && (rem_idx == IDX_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[b] <= '0;
          frz_q[b] <= 1'b0;
        end else if (clr) begin
          cnt_q[b] <= '0;
          frz_q[b] <= 1'b0;
        end else if (hit_ins) begin
          cnt_q[b] <= ins_res.nxt[CNT_W-1:0];
          if (ins_res.freeze) frz_q[b] <= 1'b1;
        end else if (hit_rem) begin
          cnt_q[b] <= rem_res.nxt[CNT_W-1:0];
        end
      end
    end
  endgenerate

  // R3: an insert into a live, unsaturated bucket raises it by one
  a_r3_insert_counts: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go && !clr && !ins_frz && (ins_cur != CNT_TOP)
    |=> cnt_q[$past(ins_idx)] == CNT_W'($past(ins_cur) + 1'b1));

  // R4: same-bucket insert and remove cancel
  a_r4_collide_hold: assert property (@(posedge clk) disable iff (!rst_n)
    collide && !clr |=> cnt_q[$past(ins_idx)] == $past(ins_cur));

  // R5: a frozen bucket stays frozen at the top value
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en && ins_frz && !clr
    |=> frz_q[$past(ins_idx)] && (cnt_q[$past(ins_idx)] == CNT_TOP));

  // R9: no wrap below zero
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rem_en && !rem_frz && (rem_cur == '0) && !clr
    |=> cnt_q[$past(rem_idx)] == '0);

  // R7: a clear leaves the probed bucket empty
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !frz_q[ins_idx] && (cnt_q[ins_idx] == '0));

endmodule

// File: rtl/bsg_freeze_monitor.sv
module bsg_freeze_monitor #(
  parameter int unsigned TOTAL        = 256,
  parameter int unsigned FREEZE_LIMIT = 4,
  localparam int unsigned FC_W = $clog2(TOTAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frz_a,
  input  logic frz_b,
  output logic flush_req
);

  logic [FC_W-1:0] frz_cnt_q, frz_cnt_nxt;
  logic            limit_hit;

  function automatic logic [FC_W-1:0] add_events(input logic [FC_W-1:0] cur,
                                                  input logic a, input logic b);
    return cur + FC_W'(a) + FC_W'(b);
  endfunction

  assign frz_cnt_nxt = add_events(frz_cnt_q, frz_a, frz_b);
  assign limit_hit   = (frz_cnt_nxt >= FC_W'(FREEZE_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_cnt_q <= '0;
      flush_req <= 1'b0;
    end else if (clr) begin
      frz_cnt_q <= '0;
      flush_req <= 1'b0;
    end else begin
      frz_cnt_q <= frz_cnt_nxt;
      if (limit_hit) flush_req <= 1'b1;
    end
  end

  // R6: the request is held until a clear
  a_r6_flush_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !clr |=> flush_req);

  // R6: the frozen count never shrinks without a clear
  a_r6_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> frz_cnt_q >= $past(frz_cnt_q));

  // R7: a clear drops the request
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flush_req && (frz_cnt_q == '0));

endmodule

// File: rtl/bloom_search_gate.sv
module bloom_search_gate #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DEPTH        = 128,
  parameter int unsigned CNT_W        = 3,
  parameter int unsigned HASH_MODE    = 1,
  parameter int unsigned FREEZE_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              iss_valid,
  input  logic              iss_store,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic              ret_valid,
  input  logic              ret_store,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              search_req,
  output logic              flush_req
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] iss_idx, ret_idx;
  logic             ld_ins, st_ins, ld_rem, st_rem;
  logic             ld_hit, st_hit;
  logic             ld_frz, st_frz;

  bsg_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HASH_MODE(HASH_MODE)) u_hash_iss (
    .addr(iss_addr), .idx(iss_idx));
  bsg_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HASH_MODE(HASH_MODE)) u_hash_ret (
    .addr(ret_addr), .idx(ret_idx));

  assign ld_ins = iss_valid && !iss_store;
  assign st_ins = iss_valid &&  iss_store;
  assign ld_rem = ret_valid && !ret_store;
  assign st_rem = ret_valid &&  ret_store;

  bsg_count_table #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ld_tbl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ins_en(ld_ins), .ins_idx(iss_idx),
    .rem_en(ld_rem), .rem_idx(ret_idx),
    .probe_idx(iss_idx), .probe_hit(ld_hit), .freeze_evt(ld_frz));

  bsg_count_table #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_st_tbl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ins_en(st_ins), .ins_idx(iss_idx),
    .rem_en(st_rem), .rem_idx(ret_idx),
    .probe_idx(iss_idx), .probe_hit(st_hit), .freeze_evt(st_frz));

  // Cross probe: loads look at stores, stores look at loads
  assign search_req = iss_valid && (iss_store ? ld_hit : st_hit);

  bsg_freeze_monitor #(.TOTAL(2 * DEPTH), .FREEZE_LIMIT(FREEZE_LIMIT)) u_frz_mon (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .frz_a(ld_frz), .frz_b(st_frz), .flush_req(flush_req));

  // R5: one operation per cycle can freeze at most one bucket
  a_r5_single_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_frz && st_frz));

  // R1: nothing is recorded right after reset
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !flush_req);

endmodule

// File: tb/bloom_search_gate_tb.sv
`timescale 1ns/100ps
module bloom_search_gate_tb;

  localparam int ADDR_W = 32;
  localparam int DEPTH  = 128;
  localparam int IDX_W  = 7;
  localparam int CNT_W  = 3;
  localparam int LIMIT  = 4;
  localparam int TOP    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic iss_valid = 1'b0, iss_store = 1'b0, ret_valid = 1'b0, ret_store = 1'b0;
  logic [ADDR_W-1:0] iss_addr = '0, ret_addr = '0;
  logic search_req, flush_req;

  always #2.5 clk = ~clk;

  bloom_search_gate #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
                      .HASH_MODE(1), .FREEZE_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .iss_valid(iss_valid), .iss_store(iss_store), .iss_addr(iss_addr),
    .ret_valid(ret_valid), .ret_store(ret_store), .ret_addr(ret_addr),
    .search_req(search_req), .flush_req(flush_req));

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  int mcnt [2][DEPTH];
  bit mfrz [2][DEPTH];
  int mfcnt;
  bit mflush;

  // R8 restated: fold the upper index-wide field onto the lower one
  function automatic int bhash(input logic [ADDR_W-1:0] a);
    return int'((a ^ (a >> IDX_W)) & (DEPTH - 1));
  endfunction

  function automatic bit exp_search(input bit st, input logic [ADDR_W-1:0] a);
    int t = st ? 0 : 1;
    int h = bhash(a);
    return mfrz[t][h] || (mcnt[t][h] != 0);
  endfunction

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++) begin
        mcnt[t][i] = 0;
        mfrz[t][i] = 1'b0;
      end
    mfcnt = 0;
    mflush = 1'b0;
  endtask

  task automatic model_update(input bit iv, input bit is, input logic [ADDR_W-1:0] ia,
                              input bit rv, input bit rs, input logic [ADDR_W-1:0] ra,
                              input bit c);
    int hi = bhash(ia);
    int hr = bhash(ra);
    int ti = is ? 1 : 0;
    int tr = rs ? 1 : 0;
    if (c) begin
      model_reset();
      return;
    end
    if (iv && rv && ti == tr && hi == hr) return;
    if (iv && !mfrz[ti][hi]) begin
      if (mcnt[ti][hi] == TOP) begin
        mfrz[ti][hi] = 1'b1;
        mfcnt++;
      end else mcnt[ti][hi]++;
    end
    if (rv && !mfrz[tr][hr] && mcnt[tr][hr] != 0) mcnt[tr][hr]--;
    if (mfcnt >= LIMIT) mflush = 1'b1;
  endtask

  task automatic check(input bit got, input bit exp, input string tag, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit iv, input bit is, input logic [ADDR_W-1:0] ia,
                      input bit rv, input bit rs, input logic [ADDR_W-1:0] ra,
                      input bit c, input string tag);
    bit es;
    @(negedge clk);
    iss_valid = iv; iss_store = is; iss_addr = ia;
    ret_valid = rv; ret_store = rs; ret_addr = ra; clr = c;
    #1;
    es = iv ? exp_search(is, ia) : 1'b0;
    check(search_req, es, tag, "search_req");
    @(posedge clk);
    #1;
    model_update(iv, is, ia, rv, rs, ra, c);
    check(flush_req, mflush, tag, "flush_req");
    iss_valid = 1'b0; ret_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic issue(input bit is, input logic [ADDR_W-1:0] a, input string tag);
    step(1'b1, is, a, 1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic retire(input bit is, input logic [ADDR_W-1:0] a, input string tag);
    step(1'b0, 1'b0, '0, 1'b1, is, a, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] pool [16];
    logic [ADDR_W-1:0] A, B, C, D;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    A = 32'h0000_1234; B = 32'h0000_0A11; C = 32'h0003_0005; D = 32'h00F0_0077;

    // R1: empty tables after reset
    check(flush_req, 1'b0, "R1", "flush after reset");
    issue(1'b1, A, "R1");
    retire(1'b1, A, "R1");

    // R2/R3: load recorded, then stores see it
    issue(1'b0, A, "R3");
    issue(1'b1, A, "R2");
    issue(1'b0, A, "R2");
    retire(1'b1, A, "R3");
    retire(1'b0, A, "R3");
    retire(1'b0, A, "R3");
    issue(1'b1, A, "R3");
    retire(1'b1, A, "R3");

    // R4: collision of insert and remove in one bucket
    issue(1'b0, B, "R4");
    step(1'b1, 1'b0, B, 1'b1, 1'b0, B, 1'b0, "R4");
    retire(1'b0, B, "R4");
    issue(1'b1, B, "R4");
    retire(1'b1, B, "R4");

    // R8: XOR aliasing and a non-aliasing neighbour
    issue(1'b0, A, "R8");
    issue(1'b1, A ^ 32'h0000_0081, "R8");
    issue(1'b1, A ^ 32'h0000_0080, "R8");
    retire(1'b1, A ^ 32'h0000_0081, "R8");
    retire(1'b1, A ^ 32'h0000_0080, "R8");
    retire(1'b0, A, "R8");

    // R9: retire on an empty bucket
    retire(1'b0, D, "R9");
    issue(1'b0, D, "R9");
    issue(1'b1, D, "R9");
    retire(1'b0, D, "R9");
    issue(1'b1, D, "R9");
    retire(1'b1, D, "R9");
    retire(1'b1, D, "R9");

    // R5: drive one load bucket past its top value
    for (int k = 0; k < TOP + 1; k++) issue(1'b0, C, "R5");
    for (int k = 0; k < TOP + 3; k++) retire(1'b0, C, "R5");
    issue(1'b1, C, "R5");
    issue(1'b1, C ^ 32'h0000_0102, "R5");

    // R6: three more freezes, split between tables
    for (int k = 0; k < TOP + 1; k++) issue(1'b1, 32'h0000_0011, "R6");
    for (int k = 0; k < TOP + 1; k++) issue(1'b0, 32'h0000_0022, "R6");
    check(flush_req, 1'b0, "R6", "one below limit");
    for (int k = 0; k < TOP + 1; k++) issue(1'b1, 32'h0000_0033, "R6");
    check(flush_req, 1'b1, "R6", "at limit");
    retire(1'b1, 32'h0000_0033, "R6");
    check(flush_req, 1'b1, "R6", "held");

    // R7: clear with a simultaneous issue and retire
    step(1'b1, 1'b0, A, 1'b1, 1'b1, 32'h0000_0011, 1'b1, "R7");
    check(flush_req, 1'b0, "R7", "flush after clear");
    issue(1'b1, A, "R7");
    issue(1'b1, C, "R7");
    issue(1'b0, 32'h0000_0011, "R7");
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, "R7");

    // Random traffic over a pool with aliases
    for (int i = 0; i < 8; i++) begin
      pool[i] = $urandom;
      pool[i + 8] = pool[i] ^ ((32'($urandom) & 32'h7F) * 32'h81);
    end
    for (int n = 0; n < 4000; n++) begin
      bit iv = ($urandom % 4) != 0;
      bit rv = ($urandom % 3) == 0;
      bit c  = ($urandom % 150) == 0;
      step(iv, 1'($urandom), pool[$urandom % 16], rv, 1'($urandom),
           pool[$urandom % 16], c, "R3");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule